// File: doc/BRIEF.md
# Legacy INTx Message Aggregator

This block sits at one port of a switch or bridge and folds legacy level-interrupt messages from many downstream requesters into a single assert/deassert pair per interrupt line towards the upstream side. Each input message carries an assert-or-deassert flag, the interrupt pin it names (A to D) and the requester ID of the sender. The block records which requesters hold each of its four output lines. It sends a message upstream only when a line goes from idle to held, or from held back to idle.

A mode input picks the behaviour of the port. As a downstream port the incoming pin is used unchanged. As an upstream port the pin is rotated by the sender's device number, so that devices on the same pin spread over different lines. Every accepted input message gets exactly one answer. That answer is either a one-cycle local completion pulse or one forwarded message on a valid/ready output. While a forwarded message waits for the consumer, the input is stalled.

Top module: `intx_agg`

## Requirements
- R1: After reset no line is held, the output and completion strobes are low, and the input is ready.
- R2: In downstream-port mode (`upstream_mode_i`=0) the output line equals the incoming pin, with A=0, B=1, C=2, D=3.
- R3: In upstream-port mode the output line is ((device mod 4) + pin) mod 4, where the device is requester ID bits 7:3.
- R4: An assert on a line that is not held is forwarded as an assert (`out_deassert_o`=0) carrying the output line code, and the line becomes held.
- R5: An assert on a line that is already held is completed locally and forwards nothing. This holds whether the contributor is new or is already in the set.
- R6: A deassert that leaves other contributors on the line is completed locally and forwards nothing.
- R7: A deassert that removes the last contributor clears the line and forwards exactly one deassert (`out_deassert_o`=1) carrying the output line code.
- R8: A deassert from a contributor that is not on the line leaves the line's state unchanged and is completed locally.
- R9: The contributor key is requester ID bits 7:0 only. Messages that differ only in ID bits 15:8 count as the same contributor.
- R10: While a forwarded message is not yet taken (`out_valid_o`=1, `out_ready_i`=0), `in_ready_o` is low and the message fields stay stable.
- R11: Each accepted input message produces exactly one response in the next cycle. The response is either a one-cycle `cpl_o` pulse or the raising of `out_valid_o`, never both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| upstream_mode_i | input | 1 | 1: upstream-port pin rotation, 0: downstream-port pass-through |
| in_valid_i | input | 1 | Input message valid |
| in_ready_o | output | 1 | Input can be accepted |
| in_deassert_i | input | 1 | 1: deassert message, 0: assert message |
| in_pin_i | input | 2 | Incoming interrupt pin, A=0 to D=3 |
| in_req_id_i | input | 16 | Requester ID of the sender |
| cpl_o | output | 1 | One-cycle pulse for a locally completed message |
| out_valid_o | output | 1 | Forwarded message valid |
| out_ready_i | input | 1 | Consumer takes the forwarded message |
| out_deassert_o | output | 1 | Forwarded message is a deassert |
| out_line_o | output | 2 | Output line code of the forwarded message |

## Verification
A wrong contributor set does not show up when the damage is done. It shows up at a later deassert. A lost bit makes a line release too early and forward a deassert while other contributors still hold it. A stuck bit keeps a line held, so the final deassert is answered locally and no release ever goes out. The bench therefore runs sequences where several contributors share a line and drains every line before the end. This turns a hidden set error into a wrong response kind within a few messages. A wrong rotation, or a wrong held flag, shows at once as a wrong line code or as a forward where a local completion is due. Both appear in the cycle after the message is accepted.

// File: rtl/intx_pkg.sv
package intx_pkg;
  typedef enum logic [1:0] {
    PIN_A = 2'd0,
    PIN_B = 2'd1,
    PIN_C = 2'd2,
    PIN_D = 2'd3
  } intx_pin_e;

  typedef struct packed {
    logic       deassert;
    logic [1:0] line;
  } intx_msg_t;
endpackage

// File: rtl/intx_line_map.sv
module intx_line_map #(
  parameter int NUM_LINES = 4,
  parameter int KEY_W     = 8,
  parameter int DEV_LSB   = 3,
  localparam int LINE_W   = $clog2(NUM_LINES)
) (
  input  logic              upstream_mode_i,
  input  logic [LINE_W-1:0] pin_i,
  input  logic [KEY_W-1:0]  key_i,
  output logic [LINE_W-1:0] line_o
);
  logic [KEY_W-DEV_LSB-1:0] dev;
  logic [LINE_W-1:0]        rot;

  assign dev = key_i[KEY_W-1:DEV_LSB];
  // power-of-two line count: mod is truncation
  assign rot = dev[LINE_W-1:0] + pin_i;
  assign line_o = upstream_mode_i ? rot : pin_i;
endmodule

// File: rtl/intx_line_set.sv
module intx_line_set #(
  parameter int KEY_W  = 8,
  localparam int SET_W = 1 << KEY_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hit_i,
  input  logic             deassert_i,
  input  logic [KEY_W-1:0] key_i,
  output logic             fwd_o,
  output logic             pend_o,
  output logic             held_o
);
  logic [SET_W-1:0] set_q, set_d, key_bit, set_clr;
  logic             pend_q, pend_d, clr_empty;

  assign key_bit   = SET_W'(1) << key_i;
  assign set_clr   = set_q & ~key_bit;
  assign clr_empty = (set_clr == '0);

  // forward decision for a message aimed at this line
  assign fwd_o = deassert_i ? (pend_q && clr_empty) : !pend_q;

  always_comb begin
    set_d  = set_q;
    pend_d = pend_q;
    if (hit_i) begin
      if (deassert_i) begin
        set_d = set_clr;
        if (clr_empty) pend_d = 1'b0;
      end else begin
        set_d  = set_q | key_bit;
        pend_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      set_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      set_q  <= set_d;
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;
  assign held_o = |set_q;
endmodule

// File: rtl/intx_agg.sv
module intx_agg #(
  parameter int NUM_LINES = 4,
  parameter int KEY_W     = 8,
  parameter int DEV_LSB   = 3,
  parameter int REQ_W     = 16,
  localparam int LINE_W   = $clog2(NUM_LINES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upstream_mode_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic              in_deassert_i,
  input  logic [LINE_W-1:0] in_pin_i,
  input  logic [REQ_W-1:0]  in_req_id_i,
  output logic              cpl_o,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic              out_deassert_o,
  output logic [LINE_W-1:0] out_line_o
);
  logic [KEY_W-1:0]     key;
  logic [LINE_W-1:0]    line;
  logic                 accept, fwd;
  logic [NUM_LINES-1:0] fwd_vec, pend_vec, held_vec;

  logic              out_valid_q, out_deassert_q, cpl_q;
  logic [LINE_W-1:0] out_line_q;

  assign key    = in_req_id_i[KEY_W-1:0];
  assign accept = in_valid_i && in_ready_o;

  intx_line_map #(
    .NUM_LINES(NUM_LINES), .KEY_W(KEY_W), .DEV_LSB(DEV_LSB)
  ) u_map (
    .upstream_mode_i(upstream_mode_i),
    .pin_i          (in_pin_i),
    .key_i          (key),
    .line_o         (line)
  );

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    intx_line_set #(.KEY_W(KEY_W)) u_set (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .hit_i     (accept && (line == LINE_W'(g))),
      .deassert_i(in_deassert_i),
      .key_i     (key),
      .fwd_o     (fwd_vec[g]),
      .pend_o    (pend_vec[g]),
      .held_o    (held_vec[g])
    );
  end

  assign fwd = fwd_vec[line];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_q    <= 1'b0;
      out_deassert_q <= 1'b0;
      out_line_q     <= '0;
      cpl_q          <= 1'b0;
    end else begin
      cpl_q <= accept && !fwd;
      if (accept && fwd) begin
        out_valid_q    <= 1'b1;
        out_deassert_q <= in_deassert_i;
        out_line_q     <= line;
      end else if (out_ready_i) begin
        out_valid_q <= 1'b0;
      end
    end
  end

  // one forwarded message outstanding at a time
  assign in_ready_o     = !out_valid_q;
  assign cpl_o          = cpl_q;
  assign out_valid_o    = out_valid_q;
  assign out_deassert_o = out_deassert_q;
  assign out_line_o     = out_line_q;
endmodule

// File: rtl/intx_agg_chk.sv
module intx_agg_chk #(
  parameter int NUM_LINES = 4,
  parameter int LINE_W    = 2
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 in_valid_i,
  input logic                 in_ready_o,
  input logic                 cpl_o,
  input logic                 out_valid_o,
  input logic                 out_ready_i,
  input logic                 out_deassert_o,
  input logic [LINE_W-1:0]    out_line_o,
  input logic [NUM_LINES-1:0] pend_vec,
  input logic [NUM_LINES-1:0] held_vec
);
  logic acc;
  assign acc = in_valid_i && in_ready_o;

  a_r10_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !in_ready_o);

  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=>
      (out_valid_o && $stable(out_line_o) && $stable(out_deassert_o)));

  a_r11_one_resp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> (cpl_o != out_valid_o));

  a_r11_cpl_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc |=> !cpl_o);

  // R4 R7: held flag tracks the contributor set
  a_r7_pend_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_vec == held_vec);
endmodule

bind intx_agg intx_agg_chk #(.NUM_LINES(NUM_LINES), .LINE_W(LINE_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .in_valid_i    (in_valid_i),
  .in_ready_o    (in_ready_o),
  .cpl_o         (cpl_o),
  .out_valid_o   (out_valid_o),
  .out_ready_i   (out_ready_i),
  .out_deassert_o(out_deassert_o),
  .out_line_o    (out_line_o),
  .pend_vec      (pend_vec),
  .held_vec      (held_vec)
);

// File: tb/intx_agg_tb.sv
`timescale 1ns/1ps
module intx_agg_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        up_mode = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        in_deas = 1'b0;
  logic [1:0]  in_pin = '0;
  logic [15:0] in_id = '0;
  logic        cpl;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic        out_deas;
  logic [1:0]  out_line;

  int checks = 0;
  int errors = 0;

  // expected: {fwd, deassert, line}
  logic [3:0]   exp_q[$];
  string        tag_q[$];
  logic [255:0] model[4];

  always #2 clk = ~clk;

  intx_agg u_dut (
    .clk_i(clk), .rst_ni(rst_n), .upstream_mode_i(up_mode),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_deassert_i(in_deas),
    .in_pin_i(in_pin), .in_req_id_i(in_id), .cpl_o(cpl),
    .out_valid_o(out_valid), .out_ready_i(out_ready),
    .out_deassert_o(out_deas), .out_line_o(out_line)
  );

  task automatic check(input bit ok, input string tag, input string msg);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s", tag, msg);
    end
  endtask

  task automatic send(input bit deas, input logic [1:0] pin,
                      input logic [15:0] id, input string tag);
    logic [7:0] key;
    logic [1:0] ln;
    bit         fw, was;
    key = id[7:0];
    ln  = up_mode ? 2'(key[4:3] + pin) : pin;
    if (!deas) begin
      fw = (model[ln] == '0);
      model[ln][key] = 1'b1;
    end else begin
      was = (model[ln] != '0);
      model[ln][key] = 1'b0;
      fw = was && (model[ln] == '0);
    end
    exp_q.push_back({fw, deas, ln});
    tag_q.push_back(tag);
    @(negedge clk);
    in_valid = 1'b1; in_deas = deas; in_pin = pin; in_id = id;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && (cpl || (out_valid && out_ready))) begin
      logic [3:0] e;
      string t;
      if (exp_q.size() == 0) begin
        check(1'b0, "R11", "response with no message pending");
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (cpl)
          check(!e[3], t, $sformatf("local completion, expected fwd=%0b de=%0b line=%0d",
                e[3], e[2], e[1:0]));
        else
          check(e[3] && out_deas == e[2] && out_line == e[1:0], t,
                $sformatf("fwd de=%0b line=%0d, expected fwd=%0b de=%0b line=%0d",
                out_deas, out_line, e[3], e[2], e[1:0]));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid && !cpl && in_ready, "R1",
          $sformatf("valid=%0b cpl=%0b ready=%0b, expected 0 0 1", out_valid, cpl, in_ready));

    // downstream mode
    send(0, 2'd1, 16'h0108, "R2_R4");
    send(0, 2'd1, 16'h0210, "R5");
    send(0, 2'd1, 16'h0108, "R5");
    send(1, 2'd1, 16'h0108, "R6");
    send(1, 2'd1, 16'h0333, "R8");
    send(1, 2'd1, 16'h0510, "R9_R7");
    send(1, 2'd2, 16'h0001, "R8");
    send(0, 2'd3, 16'h0040, "R2_R4");
    send(1, 2'd3, 16'hFF40, "R9_R7");

    // upstream mode
    repeat (2) @(negedge clk);
    up_mode = 1'b1;
    send(0, 2'd0, 16'h0018, "R3_R4");
    send(0, 2'd3, 16'h0008, "R3_R4");
    send(0, 2'd2, 16'h0010, "R3_R5");
    send(1, 2'd3, 16'h0008, "R3_R6");
    send(1, 2'd2, 16'h0010, "R3_R7");
    send(1, 2'd0, 16'h0018, "R3_R7");

    // back-pressure
    repeat (2) @(negedge clk);
    up_mode = 1'b0;
    out_ready = 1'b0;
    send(0, 2'd0, 16'h0000, "R10");
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      check(!in_ready && out_valid && out_line == 2'd0 && !out_deas, "R10",
            $sformatf("ready=%0b valid=%0b line=%0d de=%0b, expected 0 1 0 0",
            in_ready, out_valid, out_line, out_deas));
    end
    out_ready = 1'b1;
    send(1, 2'd0, 16'h0000, "R7");

    // sweep: many contributors, upstream mode, then drain
    repeat (2) @(negedge clk);
    up_mode = 1'b1;
    for (int d = 0; d < 8; d++)
      send(0, 2'(d), {8'h00, 5'(d), 3'(d)}, "R11");
    for (int d = 0; d < 8; d++)
      send(1, 2'(d), {8'h00, 5'(d), 3'(d)}, "R11");

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R11",
          $sformatf("%0d responses missing, expected 0", exp_q.size()));
    check(!out_valid && !cpl, "R7",
          $sformatf("valid=%0b cpl=%0b after drain, expected 0 0", out_valid, cpl));
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule